// File: doc/BRIEF.md
# Serial Flash Page-Program Engine

This block holds the storage array of a small serial NOR flash together with the logic that writes it. A controller opens a program session with a start address, streams bytes into a one-page staging buffer, and then closes the session. The close starts a timed cycle. During that cycle each staged byte is combined with the byte already stored, so programming can only turn ones into zeros. Separate page-erase and sector-erase commands bring a whole range back to all ones.

A busy flag is high for the full length of every program or erase cycle, and a controller polls it to learn when the cycle has finished. While the flag is high the block rejects all commands and data. A registered read port lets the surrounding logic, or a test, inspect any byte. The page is 256 bytes. With the default parameters a sector is four pages and the array holds two sectors (2048 bytes).

Top module: `nor_page_prog`

## Requirements
- R1: After reset `busy` is 0 and no session is open. The array comes up fully erased: every byte reads 8'hFF.
- R2: `cmd_op` 2'd0 opens a program session at `cmd_addr`. Each cycle with `wr_valid` stages one byte at the next page offset. `cmd_op` 2'd3 closes the session and starts the cycle. The array does not change while bytes are being staged.
- R3: A programmed byte becomes stored AND supplied. A stored 0 bit stays 0 whatever value is supplied.
- R4: The offset advances modulo 256 inside the page of the start address, so a stream that runs past byte 255 continues at byte 0 of the same page.
- R5: At most 256 bytes are programmed per session. When more than 256 are sent, a later byte replaces the earlier one staged at the same offset, and the cycle length is that of 256 bytes.
- R6: `cmd_op` 2'd1 sets all 256 bytes of the page containing `cmd_addr` to 8'hFF and leaves the other pages unchanged.
- R7: `cmd_op` 2'd2 sets every byte of the aligned sector (SECT_PAGES pages) containing `cmd_addr` to 8'hFF and leaves the other sectors unchanged.
- R8: `busy` rises in the cycle after a cycle is accepted and stays high for exactly W+N+1 cycles. For a program, W is W_PROG and N is the staged byte count. For a page erase, W is W_PE and N is 256. For a sector erase, W is W_SE and N is 256*SECT_PAGES.
- R9: While `busy` is high, commands and `wr_valid` are ignored. They neither change the array nor lengthen the cycle.
- R10: A close with no staged bytes returns to idle without a cycle. `wr_valid` outside a session is ignored. Open and erase commands during an open session are ignored.
- R11: Programming bytes in one session takes fewer busy cycles than splitting the same bytes over two sessions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 open program, 1 page erase, 2 sector erase, 3 close program |
| cmd_addr | input | AW | Byte address for open and erase commands |
| wr_valid | input | 1 | Data byte strobe during a program session |
| wr_data | input | DW | Data byte to stage |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Byte at rd_addr, one cycle later |
| busy | output | 1 | Write-in-progress flag |

## Verification
The bench targets these corner cases:
- A stream that crosses the page end. A design that carries into the next page corrupts the neighbour page at 0x200.
- A stream longer than a page. A design that does not saturate its count reports a busy length that is too long, or writes stale data.
- A second program over bytes that already hold zeros. Overwriting instead of merging brings bits back to one.
- An erase whose address sits mid-page or mid-sector. Wrong alignment erases the wrong range.
- Commands sent during an active cycle. A design that accepts them alters byte 0x455 or stretches the busy window.

A behavioural reference model runs in parallel with the design and compares the busy flag and the read data on every clock.

// File: rtl/npp_pkg.sv
package npp_pkg;
  typedef enum logic [1:0] {
    OP_OPEN   = 2'd0,
    OP_PERASE = 2'd1,
    OP_SERASE = 2'd2,
    OP_CLOSE  = 2'd3
  } npp_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_WAIT,
    ST_WALK,
    ST_DRAIN
  } npp_st_e;
endpackage

// File: rtl/npp_pagebuf.sv
module npp_pagebuf #(
  parameter int DW      = 8,
  parameter int PAGE_AW = 8
) (
  input  logic               clk,
  input  logic               we,
  input  logic [PAGE_AW-1:0] waddr,
  input  logic [DW-1:0]      wdata,
  input  logic [PAGE_AW-1:0] raddr,
  output logic [DW-1:0]      rdata
);
  localparam int PAGE_N = 1 << PAGE_AW;

  logic [DW-1:0] mem [PAGE_N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/npp_array.sv
module npp_array #(
  parameter int DW = 8,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rq,
  input  logic [AW-1:0] pa,
  output logic [DW-1:0] pq
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // shipped state: fully erased
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rq <= mem[ra];
    pq <= mem[pa];
  end
endmodule

// File: rtl/npp_ctrl.sv
module npp_ctrl import npp_pkg::*; #(
  parameter int PAGE_AW = 8,
  parameter int SECT_PW = 2,
  parameter int AW      = 11,
  parameter int W_PROG  = 8,
  parameter int W_PE    = 20,
  parameter int W_SE    = 40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic [AW-1:0]      cmd_addr,
  input  logic               wr_valid,
  output logic               busy,
  output logic               loading,
  output logic               buf_we,
  output logic [PAGE_AW-1:0] buf_waddr,
  output logic [PAGE_AW-1:0] buf_raddr,
  output logic [AW-1:0]      arr_ra,
  output logic               arr_we,
  output logic [AW-1:0]      arr_wa,
  output logic               is_prog
);
  localparam int IW     = PAGE_AW + SECT_PW;
  localparam int CW     = PAGE_AW + 1;
  localparam int WW     = 16;
  localparam int PAGE_N = 1 << PAGE_AW;
  localparam logic [CW-1:0] CNT_MAX = CW'(PAGE_N);
  localparam logic [IW:0]   N_PAGE  = (IW+1)'(PAGE_N);
  localparam logic [IW:0]   N_SECT  = (IW+1)'(1 << IW);

  npp_st_e st, st_n;
  npp_op_e op_in;
  logic               prog_q, pend_q, busy_q;
  logic [AW-1:0]      base_q, wa_q, walk_addr;
  logic [PAGE_AW-1:0] ptr_q;
  logic [CW-1:0]      cnt_q;
  logic [IW-1:0]      idx_q;
  logic [IW:0]        nwalk_q;
  logic [WW-1:0]      wt_q;
  logic               close_hit, byte_hit, walk_last;

  assign op_in     = npp_op_e'(cmd_op);
  assign close_hit = cmd_valid && (op_in == OP_CLOSE);
  assign byte_hit  = (st == ST_LOAD) && wr_valid && !close_hit;
  assign walk_last = ({1'b0, idx_q} == nwalk_q - 1'b1);

  always_comb begin
    if (prog_q)
      walk_addr = {base_q[AW-1:PAGE_AW], base_q[PAGE_AW-1:0] + idx_q[PAGE_AW-1:0]};
    else
      walk_addr = base_q + AW'(idx_q);
  end

  always_comb begin
    st_n = st;
    case (st)
      ST_IDLE:
        if (cmd_valid) begin
          if (op_in == OP_OPEN) st_n = ST_LOAD;
          else if (op_in == OP_PERASE || op_in == OP_SERASE) st_n = ST_WAIT;
        end
      ST_LOAD:  if (close_hit) st_n = (cnt_q == '0) ? ST_IDLE : ST_WAIT;
      ST_WAIT:  if (wt_q == '0) st_n = ST_WALK;
      ST_WALK:  if (walk_last) st_n = ST_DRAIN;
      ST_DRAIN: st_n = ST_IDLE;
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      busy_q  <= 1'b0;
      pend_q  <= 1'b0;
      prog_q  <= 1'b0;
      base_q  <= '0;
      wa_q    <= '0;
      ptr_q   <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      nwalk_q <= '0;
      wt_q    <= '0;
    end else begin
      st     <= st_n;
      busy_q <= (st_n == ST_WAIT) || (st_n == ST_WALK) || (st_n == ST_DRAIN);
      pend_q <= (st == ST_WALK);
      wa_q   <= walk_addr;
      case (st)
        ST_IDLE:
          if (cmd_valid) begin
            case (op_in)
              OP_OPEN: begin
                prog_q <= 1'b1;
                base_q <= cmd_addr;
                ptr_q  <= cmd_addr[PAGE_AW-1:0];
                cnt_q  <= '0;
              end
              OP_PERASE: begin
                prog_q  <= 1'b0;
                base_q  <= {cmd_addr[AW-1:PAGE_AW], {PAGE_AW{1'b0}}};
                nwalk_q <= N_PAGE;
                wt_q    <= WW'(W_PE - 1);
              end
              OP_SERASE: begin
                prog_q  <= 1'b0;
                base_q  <= {cmd_addr[AW-1:IW], {IW{1'b0}}};
                nwalk_q <= N_SECT;
                wt_q    <= WW'(W_SE - 1);
              end
              default: ;
            endcase
          end
        ST_LOAD:
          if (close_hit) begin
            nwalk_q <= (IW+1)'(cnt_q);
            wt_q    <= WW'(W_PROG - 1);
          end else if (byte_hit) begin
            ptr_q <= ptr_q + 1'b1;
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
          end
        ST_WAIT:
          if (wt_q == '0) idx_q <= '0;
          else            wt_q  <= wt_q - 1'b1;
        ST_WALK:
          if (!walk_last) idx_q <= idx_q + 1'b1;
        default: ;
      endcase
    end
  end

  assign busy      = busy_q;
  assign loading   = (st == ST_LOAD);
  assign buf_we    = byte_hit;
  assign buf_waddr = ptr_q;
  assign buf_raddr = walk_addr[PAGE_AW-1:0];
  assign arr_ra    = walk_addr;
  assign arr_we    = pend_q;
  assign arr_wa    = wa_q;
  assign is_prog   = prog_q;
endmodule

// File: rtl/nor_page_prog.sv
module nor_page_prog #(
  parameter int DW      = 8,
  parameter int PAGE_AW = 8,
  parameter int SECT_PW = 2,
  parameter int NSECT_W = 1,
  parameter int W_PROG  = 8,
  parameter int W_PE    = 20,
  parameter int W_SE    = 40,
  localparam int AW     = PAGE_AW + SECT_PW + NSECT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          busy
);
  logic               loading, buf_we, arr_we, is_prog;
  logic [PAGE_AW-1:0] buf_waddr, buf_raddr;
  logic [AW-1:0]      arr_ra, arr_wa;
  logic [DW-1:0]      buf_q, arr_q, merged;

  npp_ctrl #(
    .PAGE_AW(PAGE_AW), .SECT_PW(SECT_PW), .AW(AW),
    .W_PROG(W_PROG), .W_PE(W_PE), .W_SE(W_SE)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .wr_valid(wr_valid), .busy(busy), .loading(loading),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_raddr(buf_raddr),
    .arr_ra(arr_ra), .arr_we(arr_we), .arr_wa(arr_wa), .is_prog(is_prog)
  );

  npp_pagebuf #(.DW(DW), .PAGE_AW(PAGE_AW)) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(wr_data),
    .raddr(buf_raddr), .rdata(buf_q)
  );

  // program only clears bits; erase drives all ones
  assign merged = is_prog ? (arr_q & buf_q) : {DW{1'b1}};

  npp_array #(.DW(DW), .AW(AW)) u_arr (
    .clk(clk), .we(arr_we), .wa(arr_wa), .wd(merged),
    .ra(arr_ra), .rq(arr_q), .pa(rd_addr), .pq(rd_data)
  );
endmodule

// File: rtl/npp_chk.sv
module npp_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       loading,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       arr_we
);
  p_erase_starts_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !loading && cmd_valid && (cmd_op == 2'd1 || cmd_op == 2'd2)) |=> busy);

  p_fall_no_write_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !arr_we);

  p_no_write_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !arr_we);

  p_modes_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({busy, loading}));

  p_busy_blocks_open_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_valid) |=> !loading);

  p_empty_close_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !loading && cmd_valid && cmd_op == 2'd3) |=> (!busy && !loading));

  p_load_holds_r10: assert property (@(posedge clk) disable iff (rst)
    (loading && !(cmd_valid && cmd_op == 2'd3)) |=> loading);
endmodule

bind nor_page_prog npp_chk u_npp_chk (
  .clk(clk), .rst(rst), .busy(busy), .loading(loading),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op), .arr_we(arr_we)
);

// File: tb/nor_page_prog_bench.sv
module nor_page_prog_bench;
  localparam int AW = 11, WP = 8, WPE = 20, WSE = 40, SPG = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, wr_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [AW-1:0] cmd_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic busy;
  bit done = 0;

  always #2.5 clk = ~clk;

  nor_page_prog #(.W_PROG(WP), .W_PE(WPE), .W_SE(WSE)) u_nor_page_prog (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [7:0] mmem [0:(1<<AW)-1];
  logic [7:0] mbuf [0:255];
  int mst = 0, mptr = 0, mcnt = 0, mbusy = 0, mop = 0, mbase = 0;
  logic [7:0] exp_rd;
  bit rd_ok = 0;

  initial for (int i = 0; i < (1<<AW); i++) mmem[i] = 8'hFF;

  task automatic apply_op();
    if (mop == 0) begin
      for (int k = 0; k < mcnt; k++) begin
        int off = (mbase % 256 + k) % 256;
        int a = (mbase / 256) * 256 + off;
        mmem[a] = mmem[a] & mbuf[off];
      end
    end else begin
      int n = (mop == 1) ? 256 : 256 * SPG;
      for (int k = 0; k < n; k++) mmem[mbase + k] = 8'hFF;
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      mst = 0; mbusy = 0; rd_ok = 0;
    end else begin
      exp_rd = mmem[rd_addr];
      rd_ok  = (mbusy == 0);
      if (mbusy > 0) begin
        mbusy--;
        if (mbusy == 0) apply_op();
      end else if (mst == 0) begin
        if (cmd_valid) begin
          if (cmd_op == 2'd0) begin
            mst = 1; mbase = int'(cmd_addr); mptr = int'(cmd_addr) % 256; mcnt = 0;
          end else if (cmd_op == 2'd1) begin
            mop = 1; mbase = (int'(cmd_addr) / 256) * 256; mbusy = WPE + 256 + 1;
          end else if (cmd_op == 2'd2) begin
            mop = 2; mbase = (int'(cmd_addr) / (256*SPG)) * (256*SPG); mbusy = WSE + 256*SPG + 1;
          end
        end
      end else begin
        if (cmd_valid && cmd_op == 2'd3) begin
          mst = 0;
          if (mcnt > 0) begin mop = 0; mbusy = WP + mcnt + 1; end
        end else if (wr_valid) begin
          mbuf[mptr] = wr_data;
          mptr = (mptr + 1) % 256;
          if (mcnt < 256) mcnt++;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R8", {31'd0, busy}, {31'd0, mbusy > 0}, "busy vs model");
      if (rd_ok) chk("R3", {24'd0, rd_data}, {24'd0, exp_rd}, "rd_data vs model");
    end
  end

  task automatic cmd(input logic [1:0] op, input logic [AW-1:0] a);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic send(input logic [7:0] d);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy) begin @(negedge clk); cyc++; end
  endtask

  task automatic peek(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
    rd_addr = a;
    @(negedge clk);
    chk(tag, {24'd0, rd_data}, {24'd0, exp}, $sformatf("byte at %0h", a));
  endtask

  task automatic summary();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int cyc, c2, c3, extra;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1", {31'd0, busy}, 32'd0, "busy after reset");
    peek(11'h000, 8'hFF, "R1");
    peek(11'h7FF, 8'hFF, "R1");

    // R2: staged bytes do not reach the array before close
    cmd(2'd0, 11'h010);
    send(8'hA5); send(8'h3C); send(8'hF0); send(8'h0F);
    peek(11'h010, 8'hFF, "R2");
    cmd(2'd3, '0);
    wait_idle(cyc);
    chk("R8", cyc, WP + 4 + 1, "program busy length");
    peek(11'h010, 8'hA5, "R2"); peek(11'h011, 8'h3C, "R2");
    peek(11'h012, 8'hF0, "R2"); peek(11'h013, 8'h0F, "R2");
    peek(11'h014, 8'hFF, "R2");

    // R3: AND merge
    cmd(2'd0, 11'h010);
    send(8'hFF); send(8'hFF); send(8'h0F); send(8'hF0);
    cmd(2'd3, '0);
    wait_idle(cyc);
    peek(11'h010, 8'hA5, "R3"); peek(11'h011, 8'h3C, "R3");
    peek(11'h012, 8'h00, "R3"); peek(11'h013, 8'h00, "R3");

    // R4: wrap inside page 1
    cmd(2'd0, 11'h1FE);
    send(8'h11); send(8'h22); send(8'h33); send(8'h44);
    cmd(2'd3, '0);
    wait_idle(cyc);
    peek(11'h1FE, 8'h11, "R4"); peek(11'h1FF, 8'h22, "R4");
    peek(11'h100, 8'h33, "R4"); peek(11'h101, 8'h44, "R4");
    peek(11'h200, 8'hFF, "R4");

    // R5: 258 bytes into page 2
    cmd(2'd0, 11'h200);
    for (int k = 0; k < 256; k++) send(8'(k));
    send(8'hC1); send(8'hC2);
    cmd(2'd3, '0);
    wait_idle(cyc);
    chk("R5", cyc, WP + 256 + 1, "saturated busy length");
    peek(11'h200, 8'hC1, "R5"); peek(11'h201, 8'hC2, "R5");
    peek(11'h202, 8'h02, "R5"); peek(11'h2FE, 8'hFE, "R5");

    // R6: page erase mid-page address
    cmd(2'd1, 11'h1C7);
    wait_idle(cyc);
    chk("R6", cyc, WPE + 256 + 1, "page erase busy length");
    peek(11'h1FE, 8'hFF, "R6"); peek(11'h100, 8'hFF, "R6");
    peek(11'h010, 8'hA5, "R6"); peek(11'h200, 8'hC1, "R6");

    // R10: ignored data/commands
    send(8'h00);
    cmd(2'd0, 11'h300); send(8'h81); cmd(2'd3, '0);
    wait_idle(cyc);
    peek(11'h300, 8'h81, "R10"); peek(11'h301, 8'hFF, "R10");
    cmd(2'd0, 11'h310); cmd(2'd3, '0);
    @(negedge clk);
    chk("R10", {31'd0, busy}, 32'd0, "empty close no cycle");
    cmd(2'd0, 11'h320); cmd(2'd0, 11'h330); cmd(2'd1, 11'h320);
    send(8'h42); cmd(2'd3, '0);
    wait_idle(cyc);
    peek(11'h320, 8'h42, "R10"); peek(11'h330, 8'hFF, "R10");

    // R7 and R9: sector erase with commands during busy
    cmd(2'd0, 11'h455); send(8'h12); cmd(2'd3, '0);
    wait_idle(cyc);
    cmd(2'd2, 11'h2AB);
    extra = 0;
    cmd(2'd0, 11'h455); extra++;
    send(8'h00); extra++;
    cmd(2'd3, '0); extra++;
    cmd(2'd1, 11'h400); extra++;
    wait_idle(cyc);
    chk("R9", cyc + extra, WSE + 256*SPG + 1, "sector erase busy not extended");
    peek(11'h010, 8'hFF, "R7"); peek(11'h2FE, 8'hFF, "R7");
    peek(11'h300, 8'hFF, "R7"); peek(11'h455, 8'h12, "R9");

    // R11: one session beats two
    cmd(2'd0, 11'h500);
    for (int k = 0; k < 8; k++) send(8'h80 + 8'(k));
    cmd(2'd3, '0);
    wait_idle(cyc);
    cmd(2'd0, 11'h600);
    for (int k = 0; k < 4; k++) send(8'h90 + 8'(k));
    cmd(2'd3, '0);
    wait_idle(c2);
    cmd(2'd0, 11'h604);
    for (int k = 4; k < 8; k++) send(8'h90 + 8'(k));
    cmd(2'd3, '0);
    wait_idle(c3);
    chk("R11", {31'd0, cyc < c2 + c3}, 32'd1, "single session shorter");
    chk("R8", cyc, WP + 8 + 1, "eight byte busy length");
    peek(11'h507, 8'h87, "R11"); peek(11'h607, 8'h97, "R11");

    repeat (3) @(negedge clk);
    summary();
  end
endmodule